// File: doc/BRIEF.md
# Two-Class Flit Interleaving Multiplexer

This block sits at the input side of one router module and merges two flit streams onto a single shared internal channel. One stream carries guaranteed-service traffic and the other best-effort traffic. Time slots on the channel are handed out dynamically, one flit at a time. If both classes can move a flit, the slots alternate strictly. If only one class can move, that class takes every slot. Each class therefore gets at least half of the channel whenever it has work, and no slot is left idle while either class could use it.

A flit's class comes from the input port it arrives on. Every flit that leaves is tagged with that class, so the output multiplexers further on can steer it into the matching per-class queue. The block holds no flit storage. A flit passes from the granted input to the channel in the same cycle, and the acceptance comes back from the downstream queue of that class. Packets are framed with begin and end marks and use wormhole switching. Packets of the two classes may interleave flit by flit, so each class keeps its own record of the destination field taken from its current packet's head flit. That destination is presented with every flit of the packet.

Back-pressure rules: each input follows valid/ready. Once a source raises valid, it holds the flit stable until it sees ready. Downstream acceptance is split by class into `ch_gs_ready` and `ch_be_ready`. These signals must not depend on `ch_valid` or `ch_class`. The block may, however, make `ch_valid` and the input readies depend on them, which lets a blocked class yield its slot. A transfer happens on a cycle where `ch_valid` is high and the ready of the tagged class is high. In that same cycle the matching input ready is high.

Top module: `flit_class_mux`

## Requirements
- R1: After reset, the first cycle in which both classes can advance (valid high and the class's downstream ready high) grants the guaranteed-service class, with `ch_class` = 1.
- R2: In consecutive transfers where both classes can advance, the granted class alternates flit by flit, with `ch_class` = 1 for guaranteed service and 0 for best effort.
- R3: When only one class can advance, either because the other has no valid flit or because the other's downstream ready is low, that class is granted in every such cycle.
- R4: The slot pointer changes only on a transfer. Cycles with no transfer leave the next winner of a contested slot unchanged.
- R5: `ch_data`, `ch_bop` and `ch_eop` equal the granted input's fields in the same cycle, with no cycle of delay.
- R6: `gs_ready` is high only in a cycle where a guaranteed-service flit is transferred, and `be_ready` likewise for best effort. The two are never high together.
- R7: `ch_valid` is low in any cycle where neither class can advance.
- R8: `ch_dest` equals bits [DEST_W-1:0] of `ch_data` on a head flit (`ch_bop` = 1). On every later flit of a packet it equals the destination captured from that class's own head flit, regardless of flits of the other class in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Router clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gs_valid | input | 1 | Guaranteed-service flit offered |
| gs_ready | output | 1 | Guaranteed-service flit taken this cycle |
| gs_data | input | DATA_W | Guaranteed-service flit payload |
| gs_bop | input | 1 | Guaranteed-service head-flit mark |
| gs_eop | input | 1 | Guaranteed-service tail-flit mark |
| be_valid | input | 1 | Best-effort flit offered |
| be_ready | output | 1 | Best-effort flit taken this cycle |
| be_data | input | DATA_W | Best-effort flit payload |
| be_bop | input | 1 | Best-effort head-flit mark |
| be_eop | input | 1 | Best-effort tail-flit mark |
| ch_valid | output | 1 | Shared channel carries a flit |
| ch_class | output | 1 | Class tag: 1 guaranteed service, 0 best effort |
| ch_data | output | DATA_W | Flit payload on the channel |
| ch_bop | output | 1 | Head-flit mark on the channel |
| ch_eop | output | 1 | Tail-flit mark on the channel |
| ch_dest | output | DEST_W | Destination of the packet the flit belongs to |
| ch_gs_ready | input | 1 | Downstream guaranteed-service queue can accept |
| ch_be_ready | input | 1 | Downstream best-effort queue can accept |

## Verification
The assertions assume that the sources obey framing. Each class opens a packet with a head flit before sending body flits, and a flit is held stable while valid is high and ready is low. They also assume that the two downstream readies do not react to the channel outputs. The stimulus keeps to these rules by driving inputs only between clock edges from fixed per-cycle settings. The readies are plain levels set ahead of each cycle, and the packet tests offer flits in head, body, tail order, with a class's flit index advancing only after that class has been granted.

// File: rtl/flit_class_mux_pkg.sv
package flit_class_mux_pkg;
  localparam int unsigned NUM_CLASSES = 2;
  localparam int unsigned CLS_IDX_BE  = 0;
  localparam int unsigned CLS_IDX_GS  = 1;

  typedef enum logic {
    TRAFFIC_BE = 1'b0,
    TRAFFIC_GS = 1'b1
  } traffic_class_e;
endpackage

// File: rtl/slot_rr_arbiter.sv
module slot_rr_arbiter
  import flit_class_mux_pkg::*;
#(
  parameter int unsigned RESET_FAVOUR = CLS_IDX_GS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLASSES-1:0] can_go,
  output logic [NUM_CLASSES-1:0] grant
);
  logic fav_q;
  logic other;

  assign other = ~fav_q;

  always_comb begin
    grant = '0;
    if (can_go[fav_q]) begin
      grant[fav_q] = 1'b1;
    end else if (can_go[other]) begin
      grant[other] = 1'b1;
    end
  end

  // Pointer moves only on a transfer; the winner loses favour.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fav_q <= RESET_FAVOUR[0];
    end else if (|grant) begin
      fav_q <= grant[CLS_IDX_BE];
    end
  end
endmodule

// File: rtl/class_route_track.sv
module class_route_track #(
  parameter int unsigned DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              bop,
  input  logic [DEST_W-1:0] head_dest,
  output logic [DEST_W-1:0] cur_dest
);
  logic [DEST_W-1:0] dest_q;

  assign cur_dest = bop ? head_dest : dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0;
    end else if (xfer && bop) begin
      dest_q <= head_dest;
    end
  end
endmodule

// File: rtl/flit_class_mux.sv
module flit_class_mux
  import flit_class_mux_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gs_valid,
  output logic              gs_ready,
  input  logic [DATA_W-1:0] gs_data,
  input  logic              gs_bop,
  input  logic              gs_eop,
  input  logic              be_valid,
  output logic              be_ready,
  input  logic [DATA_W-1:0] be_data,
  input  logic              be_bop,
  input  logic              be_eop,
  output logic              ch_valid,
  output logic              ch_class,
  output logic [DATA_W-1:0] ch_data,
  output logic              ch_bop,
  output logic              ch_eop,
  output logic [DEST_W-1:0] ch_dest,
  input  logic              ch_gs_ready,
  input  logic              ch_be_ready
);
  logic [NUM_CLASSES-1:0] src_valid;
  logic [NUM_CLASSES-1:0] dst_ready;
  logic [NUM_CLASSES-1:0] src_bop;
  logic [NUM_CLASSES-1:0] src_eop;
  logic [NUM_CLASSES-1:0] can_go;
  logic [NUM_CLASSES-1:0] grant;
  logic [DATA_W-1:0]      src_data  [NUM_CLASSES];
  logic [DEST_W-1:0]      lane_dest [NUM_CLASSES];
  traffic_class_e         sel;

  always_comb begin
    src_valid[CLS_IDX_GS] = gs_valid;
    src_valid[CLS_IDX_BE] = be_valid;
    dst_ready[CLS_IDX_GS] = ch_gs_ready;
    dst_ready[CLS_IDX_BE] = ch_be_ready;
    src_bop[CLS_IDX_GS]   = gs_bop;
    src_bop[CLS_IDX_BE]   = be_bop;
    src_eop[CLS_IDX_GS]   = gs_eop;
    src_eop[CLS_IDX_BE]   = be_eop;
    src_data[CLS_IDX_GS]  = gs_data;
    src_data[CLS_IDX_BE]  = be_data;
  end

  // A class may take a slot only if its flit can land downstream.
  assign can_go = src_valid & dst_ready;

  slot_rr_arbiter #(.RESET_FAVOUR(CLS_IDX_GS)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .can_go (can_go),
    .grant  (grant)
  );

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lane
    class_route_track #(.DEST_W(DEST_W)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .xfer      (grant[c]),
      .bop       (src_bop[c]),
      .head_dest (src_data[c][DEST_W-1:0]),
      .cur_dest  (lane_dest[c])
    );
  end

  assign sel = grant[CLS_IDX_GS] ? TRAFFIC_GS : TRAFFIC_BE;

  always_comb begin
    ch_valid = |grant;
    ch_class = sel;
    ch_data  = src_data[sel];
    ch_bop   = src_bop[sel];
    ch_eop   = src_eop[sel];
    ch_dest  = lane_dest[sel];
    gs_ready = grant[CLS_IDX_GS];
    be_ready = grant[CLS_IDX_BE];
  end
endmodule

// File: rtl/flit_class_mux_chk.sv
module flit_class_mux_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gs_valid,
  input logic              gs_ready,
  input logic [DATA_W-1:0] gs_data,
  input logic              gs_bop,
  input logic              gs_eop,
  input logic              be_valid,
  input logic              be_ready,
  input logic [DATA_W-1:0] be_data,
  input logic              be_bop,
  input logic              be_eop,
  input logic              ch_valid,
  input logic              ch_class,
  input logic [DATA_W-1:0] ch_data,
  input logic              ch_bop,
  input logic              ch_eop,
  input logic [DEST_W-1:0] ch_dest,
  input logic              ch_gs_ready,
  input logic              ch_be_ready
);
  logic gs_can, be_can, both_can;
  logic have_last, last_gs;
  logic [DEST_W-1:0] gs_dest_q, be_dest_q;

  assign gs_can   = gs_valid && ch_gs_ready;
  assign be_can   = be_valid && ch_be_ready;
  assign both_can = gs_can && be_can;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_gs   <= 1'b0;
      gs_dest_q <= '0;
      be_dest_q <= '0;
    end else begin
      if (gs_ready || be_ready) begin
        have_last <= 1'b1;
        last_gs   <= gs_ready;
      end
      if (gs_ready && gs_bop) gs_dest_q <= gs_data[DEST_W-1:0];
      if (be_ready && be_bop) be_dest_q <= be_data[DEST_W-1:0];
    end
  end

  p_first_gs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (both_can && !have_last) |-> (ch_valid && ch_class));

  // R4: last_gs persists over idle cycles, so this also covers pointer hold.
  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (both_can && have_last) |-> (ch_valid && (ch_class != last_gs)));

  p_sole_gs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_can && !be_can) |-> (gs_ready && ch_class));

  p_sole_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_can && !gs_can) |-> (be_ready && !ch_class));

  p_pass_gs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gs_ready |-> (ch_data == gs_data && ch_bop == gs_bop && ch_eop == gs_eop));

  p_pass_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    be_ready |-> (ch_data == be_data && ch_bop == be_bop && ch_eop == be_eop));

  p_one_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gs_ready, be_ready}) <= 1);

  p_ready_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && (ch_class ? ch_gs_ready : ch_be_ready)) == (gs_ready || be_ready));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gs_can && !be_can) |-> !ch_valid);

  p_body_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && !ch_bop) |-> (ch_dest == (ch_class ? gs_dest_q : be_dest_q)));

  p_head_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && ch_bop) |-> (ch_dest == ch_data[DEST_W-1:0]));
endmodule

bind flit_class_mux flit_class_mux_chk #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .gs_valid(gs_valid), .gs_ready(gs_ready), .gs_data(gs_data),
  .gs_bop(gs_bop), .gs_eop(gs_eop),
  .be_valid(be_valid), .be_ready(be_ready), .be_data(be_data),
  .be_bop(be_bop), .be_eop(be_eop),
  .ch_valid(ch_valid), .ch_class(ch_class), .ch_data(ch_data),
  .ch_bop(ch_bop), .ch_eop(ch_eop), .ch_dest(ch_dest),
  .ch_gs_ready(ch_gs_ready), .ch_be_ready(ch_be_ready)
);

// File: tb/flit_class_mux_tb.sv
module flit_class_mux_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEST_W = 8;
  localparam logic [31:0] GS_WORD = 32'hA5A5_0011;
  localparam logic [31:0] BE_WORD = 32'h5A5A_0022;

  // {gs_valid, be_valid, ch_gs_ready, ch_be_ready, exp_valid, exp_class}
  localparam int NVEC = 14;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b1111_11,  // R1 first contest after reset -> GS
    6'b1111_10,  // R2 alternate -> BE
    6'b1111_11,  // R2 -> GS
    6'b0011_00,  // R7 idle, pointer holds
    6'b1111_10,  // R4 BE still favoured after idle
    6'b0111_10,  // R3 only BE valid
    6'b0111_10,  // R3 only BE valid again
    6'b1101_10,  // R3 GS blocked downstream -> BE
    6'b1111_11,  // R2 contest -> GS
    6'b1011_11,  // R3 only GS valid
    6'b1110_11,  // R3 BE blocked downstream -> GS
    6'b1100_00,  // R7 both blocked
    6'b1111_10,  // R4 BE favoured after blocked cycle
    6'b1011_11   // leaves pointer favouring BE
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gs_valid = 0, be_valid = 0, gs_bop = 0, gs_eop = 0, be_bop = 0, be_eop = 0;
  logic ch_gs_ready = 0, ch_be_ready = 0;
  logic [DATA_W-1:0] gs_data = '0, be_data = '0;
  logic gs_ready, be_ready, ch_valid, ch_class, ch_bop, ch_eop;
  logic [DATA_W-1:0] ch_data;
  logic [DEST_W-1:0] ch_dest;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flit_class_mux #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .gs_valid(gs_valid), .gs_ready(gs_ready), .gs_data(gs_data),
    .gs_bop(gs_bop), .gs_eop(gs_eop),
    .be_valid(be_valid), .be_ready(be_ready), .be_data(be_data),
    .be_bop(be_bop), .be_eop(be_eop),
    .ch_valid(ch_valid), .ch_class(ch_class), .ch_data(ch_data),
    .ch_bop(ch_bop), .ch_eop(ch_eop), .ch_dest(ch_dest),
    .ch_gs_ready(ch_gs_ready), .ch_be_ready(ch_be_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    gs_valid = 0; be_valid = 0; ch_gs_ready = 0; ch_be_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    #1;
    chk("R7 reset idle valid", {31'd0, ch_valid}, 32'd0);
    chk("R6 reset idle readies", {30'd0, gs_ready, be_ready}, 32'd0);

    // Table walk: single-flit packets, pointer evolves across rows.
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      gs_valid = VEC[i][5]; be_valid = VEC[i][4];
      ch_gs_ready = VEC[i][3]; ch_be_ready = VEC[i][2];
      gs_data = GS_WORD + i; be_data = BE_WORD + i;
      gs_bop = 1; gs_eop = 1; be_bop = 1; be_eop = 1;
      #1;
      chk($sformatf("R7 row %0d valid", i), {31'd0, ch_valid}, {31'd0, VEC[i][1]});
      if (VEC[i][1]) begin
        chk($sformatf("R2 R3 R4 row %0d class", i), {31'd0, ch_class}, {31'd0, VEC[i][0]});
        chk($sformatf("R5 row %0d data", i), ch_data, VEC[i][0] ? GS_WORD + i : BE_WORD + i);
      end
      chk($sformatf("R6 row %0d readies", i), {30'd0, gs_ready, be_ready},
          {30'd0, VEC[i][1] && VEC[i][0], VEC[i][1] && !VEC[i][0]});
    end

    // R1: reset returns favour to GS even though the pointer favoured BE.
    do_reset();
    gs_valid = 1; be_valid = 1; ch_gs_ready = 1; ch_be_ready = 1;
    #1;
    chk("R1 GS first after reset", {31'd0, ch_class}, 32'd1);

    // R8: two 3-flit packets interleaved; GS dest 0x05, BE dest 0x09.
    do_reset();
    ch_gs_ready = 1; ch_be_ready = 1;
    for (int k = 0; k < 6; k++) begin
      int gi, bi;
      gi = (k + 1) / 2;
      bi = k / 2;
      if (k > 0) @(negedge clk);
      gs_valid = 1; be_valid = 1;
      gs_bop = (gi == 0); gs_eop = (gi == 2);
      be_bop = (bi == 0); be_eop = (bi == 2);
      gs_data = (gi == 0) ? 32'h1000_0005 : 32'h1000_00F0 + gi;
      be_data = (bi == 0) ? 32'h2000_0009 : 32'h2000_00E0 + bi;
      #1;
      chk($sformatf("R2 flit %0d class", k), {31'd0, ch_class}, {31'd0, (k % 2) == 0});
      chk($sformatf("R8 flit %0d dest", k), {24'd0, ch_dest},
          ((k % 2) == 0) ? 32'h05 : 32'h09);
    end

    @(negedge clk);
    gs_valid = 0; be_valid = 0;
    #1;
    chk("R7 idle after packets", {31'd0, ch_valid}, 32'd0);
    summary();
  end
endmodule